// File: doc/BRIEF.md
# Six-Step Sequence Counter

This block is a free-running three-bit synchronous counter. It does not count in binary. It walks a fixed ring of six codes and moves one position on every rising clock edge. There is no enable and no load input, so the count advances on every cycle in which reset is low.

The state register is the output. The three state bits leave the block with no decoding after them, so the output is glitch-free and belongs to the same cycle as the state. Each bit is held in a JK-style storage cell. Small excitation logic derives each cell's J and K inputs from the present code.

The two codes outside the ring are 000 and 101. The excitation logic sends both of them back into the ring on the next edge, so the counter recovers by itself if it ever lands on one of them. Reset is synchronous and active high.

Top module: `six_step_counter`

## Requirements
- R1: When `rst` is high at a rising edge, `count_o` is 011 after that edge, and it stays at 011 for as long as `rst` stays high.
- R2: With `rst` low, every rising edge moves `count_o` one step along the ring 011, 111, 001, 010, 100, 110, and the step after 110 is 011. The value is read with bit 2 on the left.
- R3: The ring repeats exactly every six edges. After reset is released, `count_o` is 011 again after edges 6, 12 and 18, and it is 011 after no other edge in between.
- R4: If the state holds the unused code 000, the next edge with `rst` low gives 010, which is a ring code.
- R5: If the state holds the unused code 101, the next edge with `rst` low gives 110, which is a ring code.
- R6: Reset takes priority over counting from every state. This holds at any point in the ring and also from an unused code, and the count resumes from 011 once `rst` is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; loads 011 |
| count_o | output | 3 | Present state code, driven straight from the state cells |

## Verification
The ring is run from reset over three full periods without a break. This separates a correct successor order from one in which two codes are swapped or the period is wrong. Reset is then raised in the middle of the ring, which shows whether reset overrides a step already in progress.

Each unused code is placed into the state cells directly, since no port can reach it. The following edge shows that 000 and 101 each land on their own ring code. One more injection asserts reset while the state holds 000, which shows that reset beats recovery.

// File: rtl/seqc_pkg.sv
package seqc_pkg;
  localparam int unsigned CODE_W    = 3;
  localparam int unsigned CYCLE_LEN = 6;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t RESET_CODE = 3'b011;
  localparam code_t SPARE_LO   = 3'b000;
  localparam code_t SPARE_HI   = 3'b101;

  // True for the six ring codes, false for the two spares.
  function automatic logic is_ring_code(code_t c);
    return (c != SPARE_LO) && (c != SPARE_HI);
  endfunction

  // Specified successor on the ring; used only by checks.
  function automatic code_t ring_succ(code_t c);
    code_t n;
    case (c)
      3'b011:  n = 3'b111;
      3'b111:  n = 3'b001;
      3'b001:  n = 3'b010;
      3'b010:  n = 3'b100;
      3'b100:  n = 3'b110;
      3'b110:  n = 3'b011;
      default: n = RESET_CODE;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/seqc_excitation.sv
module seqc_excitation
  import seqc_pkg::*;
(
  input  code_t q,
  output code_t j,
  output code_t k
);
  // Bit 2: set and clear both follow bit 1, so it toggles whenever bit 1 is high.
  assign j[2] = q[1];
  assign k[2] = q[1];

  // Bit 1: always armed to set; clears when bits 2 and 0 agree.
  assign j[1] = 1'b1;
  assign k[1] = ~(q[2] ^ q[0]);

  // Bit 0: sets only from 110; clears whenever bit 1 is low.
  assign j[0] = q[2] & q[1];
  assign k[0] = ~q[1];
endmodule

// File: rtl/seqc_jk_cell.sv
module seqc_jk_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic j,
  input  logic k,
  output logic q
);
  logic q_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= RST_VAL;
    end else begin
      case ({j, k})
        2'b10:   q_r <= 1'b1;
        2'b01:   q_r <= 1'b0;
        2'b11:   q_r <= ~q_r;
        default: q_r <= q_r;
      endcase
    end
  end

  assign q = q_r;

  // JK behaviour of each cell underpins the ring order (R2)
  assert_jk_set_R2: assert property (@(posedge clk) disable iff (rst)
    (j && !k) |=> q_r);
  assert_jk_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (!j && k) |=> !q_r);
  assert_jk_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!j && !k) |=> $stable(q_r));
  assert_jk_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    (j && k) |=> (q_r != $past(q_r)));
endmodule

// File: rtl/six_step_counter.sv
module six_step_counter
  import seqc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  output logic [CODE_W-1:0]        count_o
);
  code_t state_w;
  code_t j_w;
  code_t k_w;

  seqc_excitation u_exc (
    .q (state_w),
    .j (j_w),
    .k (k_w)
  );

  for (genvar b = 0; b < CODE_W; b++) begin : g_bit
    seqc_jk_cell #(.RST_VAL(RESET_CODE[b])) u_ff (
      .clk (clk),
      .rst (rst),
      .j   (j_w[b]),
      .k   (k_w[b]),
      .q   (state_w[b])
    );
  end

  assign count_o = state_w;

  assert_ring_step_R2: assert property (@(posedge clk) disable iff (rst)
    is_ring_code(count_o) |=> (count_o == ring_succ($past(count_o))));
  assert_spare_lo_recover_R4: assert property (@(posedge clk) disable iff (rst)
    (count_o == SPARE_LO) |=> (count_o == 3'b010));
  assert_spare_hi_recover_R5: assert property (@(posedge clk) disable iff (rst)
    (count_o == SPARE_HI) |=> (count_o == 3'b110));
  assert_no_spare_twice_R4: assert property (@(posedge clk) disable iff (rst)
    !is_ring_code(count_o) |=> is_ring_code(count_o));
endmodule

// File: tb/six_step_counter_tb.sv
module six_step_counter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] count_o;
  logic [2:0] model;
  int         vectors = 0;
  int         fails   = 0;
  bit         done    = 1'b0;

  int ring[$] = '{3, 7, 1, 2, 4, 6};

  always #5 clk = ~clk;

  six_step_counter u_dut (
    .clk     (clk),
    .rst     (rst),
    .count_o (count_o)
  );

  function automatic logic [2:0] ref_next(logic [2:0] cur);
    int idx[$];
    idx = ring.find_first_index(x) with (x == int'(cur));
    if (idx.size() != 0) return 3'(ring[(idx[0] + 1) % ring.size()]);
    if (cur == 3'd0) return 3'd2;
    return 3'd6;
  endfunction

  task automatic compare(string req);
    vectors++;
    if (count_o !== model) begin
      fails++;
      $display("FAIL %s: count_o=%b expected %b at %0t", req, count_o, model, $time);
    end
  endtask

  task automatic tick(string req);
    @(posedge clk);
    model = rst ? 3'b011 : ref_next(model);
    @(negedge clk);
    compare(req);
  endtask

  task automatic inject(logic [2:0] code, string req);
    rst = 1'b1;
    tick("R6");
    rst = 1'b0;
    force u_dut.g_bit[0].u_ff.q_r = code[0];
    force u_dut.g_bit[1].u_ff.q_r = code[1];
    force u_dut.g_bit[2].u_ff.q_r = code[2];
    #1;
    release u_dut.g_bit[0].u_ff.q_r;
    release u_dut.g_bit[1].u_ff.q_r;
    release u_dut.g_bit[2].u_ff.q_r;
    model = code;
    compare(req);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    model = 3'b011;
    // R1: reset value, held over several edges
    repeat (3) tick("R1");
    rst = 1'b0;
    // R2 ring order, R3 period of six over three full periods
    for (int i = 1; i <= 18; i++) begin
      if (i % 6 == 0) tick("R3");
      else tick("R2");
    end
    // R6: reset in the middle of the ring
    repeat (3) tick("R2");
    rst = 1'b1;
    repeat (2) tick("R6");
    rst = 1'b0;
    repeat (6) tick("R2");
    // R4: spare 000 recovers to 010
    inject(3'b000, "R4");
    tick("R4");
    repeat (6) tick("R2");
    // R5: spare 101 recovers to 110
    inject(3'b101, "R5");
    tick("R5");
    repeat (6) tick("R2");
    // R6: reset wins over recovery from a spare code
    inject(3'b000, "R6");
    rst = 1'b1;
    tick("R6");
    rst = 1'b0;
    repeat (6) tick("R2");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule